// File: doc/BRIEF.md
# Operand Bypass and Load-Use Hold Unit

This block is the hazard-control logic of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It is purely combinational. Each cycle it looks at the source register numbers of the instruction now in decode and the instruction now in execute. It also looks at the destination register and flags held in the three pipeline registers that follow decode. From these it produces four outputs: a bypass select for each ALU operand, a hold signal and a flush signal.

Bypassing only takes values that already sit in a pipeline register: the execute/memory register or the memory/writeback register. Those values are fed to the start of the execute stage. Nothing is taken from logic in the middle of a stage.

A load whose result is needed by the very next instruction cannot be bypassed in time. The hazard is caught while the dependent instruction is still in decode. The unit then raises `hold` to freeze the program counter and the fetch/decode register for one cycle. In the same cycle it raises `flush` so that the control fields written into the decode/execute register are all zero: no register write, no memory read, no memory write. One cycle later the load data has reached the memory/writeback register, and the normal bypass path delivers it.

Top module: `hz_ctrl`

## Requirements
- R1: Each operand select takes only the values 2'b00 (register-file value), 2'b10 (execute/memory register value) and 2'b01 (memory/writeback register value). It is never 2'b11.
- R2: When the execute/memory register writes a register that is nonzero and equal to an execute-stage source, that operand's select is 2'b10.
- R3: When only the memory/writeback register writes a nonzero register equal to an execute-stage source, that operand's select is 2'b01.
- R4: When both later registers write the same matching register, the select is 2'b10, because the execute/memory register holds the newer result.
- R5: A destination of register 0 is never bypassed, whatever the write flag says.
- R6: A producer whose register-write flag is low is never bypassed, even when its destination matches.
- R7: `hold` is 1 when the decode/execute register holds a load (`exe_is_load` = 1) whose nonzero destination equals either decode-stage source.
- R8: `hold` is 0 when there is no load in execute, when the load's destination is register 0, or when neither decode source matches it.
- R9: `flush` is 1 in exactly the same cycles as `hold`.
- R10: The two operand selects are independent of each other, and each depends only on its own source register.
- R11: With every input at zero, as after a pipeline reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src1 | input | REG_W | First source register of the instruction in decode |
| dec_src2 | input | REG_W | Second source register of the instruction in decode |
| exe_src1 | input | REG_W | First source register of the instruction in execute |
| exe_src2 | input | REG_W | Second source register of the instruction in execute |
| exe_dst | input | REG_W | Destination held in the decode/execute register |
| exe_is_load | input | 1 | Memory-read flag held in the decode/execute register |
| mem_dst | input | REG_W | Destination held in the execute/memory register |
| mem_wen | input | 1 | Register-write flag held in the execute/memory register |
| wb_dst | input | REG_W | Destination held in the memory/writeback register |
| wb_wen | input | 1 | Register-write flag held in the memory/writeback register |
| opa_sel | output | 2 | Bypass select for ALU operand A |
| opb_sel | output | 2 | Bypass select for ALU operand B |
| hold | output | 1 | Freeze the program counter and the fetch/decode register |
| flush | output | 1 | Zero the control fields entering the decode/execute register |

## Verification
The assertions assume that every input is a settled, known value whenever it is checked. They do not assume any relation between the stages: any destination may equal any source, including register 0. The bench drives all inputs together on the falling clock edge and checks only after they have settled. Its pseudo-random sweep draws register numbers from a small range, so that matches, register 0 and low write flags all occur often alongside the hand-written table.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Operand bypass select encoding
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } byp_sel_e;

  localparam int unsigned NUM_EXE_SRC = 2;
  localparam int unsigned NUM_DEC_SRC = 2;

  // Priority pick: the younger producer wins
  function automatic byp_sel_e pick_source(input logic mem_hit, input logic wb_hit);
    if (mem_hit)     return SEL_MEM;
    else if (wb_hit) return SEL_WB;
    else             return SEL_RF;
  endfunction

endpackage

// File: rtl/hz_fwd_select.sv
module hz_fwd_select
  import hz_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wen,
  output logic [1:0]       sel,
  output logic             mem_hit,
  output logic             wb_hit
);

  // A producer is usable only if it writes a real register equal to src
  function automatic logic producer_hits(input logic [REG_W-1:0] dst,
                                         input logic             wen,
                                         input logic [REG_W-1:0] s);
    return wen && (dst != '0) && (dst == s);
  endfunction

  always_comb begin
    mem_hit = producer_hits(mem_dst, mem_wen, src);
    wb_hit  = producer_hits(wb_dst, wb_wen, src);
    sel     = pick_source(mem_hit, wb_hit);
  end

endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic [NUM_SRC*REG_W-1:0] dec_srcs,
  input  logic [REG_W-1:0]         load_dst,
  input  logic                     load_en,
  output logic                     hit
);

  logic [NUM_SRC-1:0] src_match;
  logic               load_live;

  assign load_live = load_en && (load_dst != '0);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
    assign src_match[i] = (dec_srcs[i*REG_W +: REG_W] == load_dst);
  end

  assign hit = load_live && (|src_match);

endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] dec_src1,
  input  logic [REG_W-1:0] dec_src2,
  input  logic [REG_W-1:0] exe_src1,
  input  logic [REG_W-1:0] exe_src2,
  input  logic [REG_W-1:0] exe_dst,
  input  logic             exe_is_load,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wen,
  output logic [1:0]       opa_sel,
  output logic [1:0]       opb_sel,
  output logic             hold,
  output logic             flush
);

  localparam int unsigned NX = NUM_EXE_SRC;
  localparam int unsigned ND = NUM_DEC_SRC;

  logic [REG_W-1:0]    exe_src [NX];
  logic [1:0]          sel     [NX];
  logic [NX-1:0]       mem_hit;   // named events for the checker
  logic [NX-1:0]       wb_hit;
  logic [ND*REG_W-1:0] dec_srcs;
  logic                load_use_hit;

  assign exe_src[0] = exe_src1;
  assign exe_src[1] = exe_src2;
  assign dec_srcs   = {dec_src2, dec_src1};

  for (genvar i = 0; i < NX; i++) begin : g_opnd
    hz_fwd_select #(.REG_W(REG_W)) u_sel (
      .src     (exe_src[i]),
      .mem_dst (mem_dst),
      .mem_wen (mem_wen),
      .wb_dst  (wb_dst),
      .wb_wen  (wb_wen),
      .sel     (sel[i]),
      .mem_hit (mem_hit[i]),
      .wb_hit  (wb_hit[i])
    );
  end

  hz_load_use #(.REG_W(REG_W), .NUM_SRC(ND)) u_lu (
    .dec_srcs (dec_srcs),
    .load_dst (exe_dst),
    .load_en  (exe_is_load),
    .hit      (load_use_hit)
  );

  assign opa_sel = sel[0];
  assign opb_sel = sel[1];
  assign hold    = load_use_hit;
  assign flush   = load_use_hit;

endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic [REG_W-1:0] dec_src1,
  input logic [REG_W-1:0] dec_src2,
  input logic [REG_W-1:0] exe_src1,
  input logic [REG_W-1:0] exe_dst,
  input logic             exe_is_load,
  input logic [REG_W-1:0] mem_dst,
  input logic             mem_wen,
  input logic [REG_W-1:0] wb_dst,
  input logic             wb_wen,
  input logic [1:0]       opa_sel,
  input logic [1:0]       opb_sel,
  input logic             hold,
  input logic             flush,
  input logic [1:0]       mem_hit,
  input logic [1:0]       wb_hit
);

  always_comb begin
    assert_sel_legal_R1: assert (opa_sel != 2'b11 && opb_sel != 2'b11)
      else $error("select took the unused code");
    assert_mem_byp_R2: assert (!(mem_wen && mem_dst != '0 && mem_dst == exe_src1) || opa_sel == 2'b10)
      else $error("execute/memory match not bypassed");
    assert_wb_byp_R3: assert (opa_sel != 2'b01 || (wb_hit[0] && !mem_hit[0]))
      else $error("memory/writeback select without sole match");
    assert_newer_wins_R4: assert (!(mem_hit[1] && wb_hit[1]) || opb_sel == 2'b10)
      else $error("older producer chosen");
    assert_no_zero_R5: assert (!(opa_sel == 2'b10 && mem_dst == '0) && !(opa_sel == 2'b01 && wb_dst == '0))
      else $error("register 0 bypassed");
    assert_wen_needed_R6: assert ((mem_wen || mem_hit == 2'b00) && (wb_wen || wb_hit == 2'b00))
      else $error("bypass from non-writing producer");
    assert_hold_cause_R7: assert (!hold || (exe_is_load && exe_dst != '0 && (exe_dst == dec_src1 || exe_dst == dec_src2)))
      else $error("hold without load-use dependence");
    assert_flush_pair_R9: assert (flush == hold)
      else $error("flush and hold disagree");
  end

endmodule

bind hz_ctrl hz_ctrl_chk #(.REG_W(REG_W)) u_chk (
  .dec_src1    (dec_src1),
  .dec_src2    (dec_src2),
  .exe_src1    (exe_src1),
  .exe_dst     (exe_dst),
  .exe_is_load (exe_is_load),
  .mem_dst     (mem_dst),
  .mem_wen     (mem_wen),
  .wb_dst      (wb_dst),
  .wb_wen      (wb_wen),
  .opa_sel     (opa_sel),
  .opb_sel     (opb_sel),
  .hold        (hold),
  .flush       (flush),
  .mem_hit     (mem_hit),
  .wb_hit      (wb_hit)
);

// File: tb/tb_hz_ctrl.sv
module tb_hz_ctrl;

  localparam int W = 5;

  typedef struct packed {
    logic [W-1:0] d1, d2, x1, x2, xd;
    logic         xl;
    logic [W-1:0] md;
    logic         mw;
    logic [W-1:0] wd;
    logic         ww;
    logic [1:0]   ea, eb;
    logic         es;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 1'b0, 5'd9, 1'b1, 5'd10, 1'b1, 2'b00, 2'b00, 1'b0}, // no match
    '{5'd0, 5'd0, 5'd1, 5'd2, 5'd0, 1'b0, 5'd1, 1'b1, 5'd0,  1'b0, 2'b10, 2'b00, 1'b0}, // R2 next-in-line
    '{5'd0, 5'd0, 5'd6, 5'd1, 5'd0, 1'b0, 5'd4, 1'b1, 5'd1,  1'b1, 2'b00, 2'b01, 1'b0}, // R3 two behind
    '{5'd0, 5'd0, 5'd3, 5'd3, 5'd0, 1'b0, 5'd3, 1'b1, 5'd3,  1'b1, 2'b10, 2'b10, 1'b0}, // R4 both match
    '{5'd0, 5'd0, 5'd5, 5'd2, 5'd0, 1'b0, 5'd5, 1'b0, 5'd5,  1'b1, 2'b01, 2'b00, 1'b0}, // R6 mem no write
    '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd0,  1'b1, 2'b00, 2'b00, 1'b0}, // R5 reg 0
    '{5'd8, 5'd1, 5'd0, 5'd0, 5'd8, 1'b1, 5'd0, 1'b0, 5'd0,  1'b0, 2'b00, 2'b00, 1'b1}, // R7 via src1
    '{5'd2, 5'd8, 5'd0, 5'd0, 5'd8, 1'b1, 5'd0, 1'b0, 5'd0,  1'b0, 2'b00, 2'b00, 1'b1}, // R7 via src2
    '{5'd8, 5'd8, 5'd0, 5'd0, 5'd8, 1'b0, 5'd0, 1'b0, 5'd0,  1'b0, 2'b00, 2'b00, 1'b0}, // R8 not a load
    '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b0, 5'd0,  1'b0, 2'b00, 2'b00, 1'b0}, // R8 load to r0
    '{5'd0, 5'd0, 5'd8, 5'd1, 5'd0, 1'b0, 5'd0, 1'b0, 5'd8,  1'b1, 2'b01, 2'b00, 1'b0}, // after bubble
    '{5'd0, 5'd0, 5'd4, 5'd4, 5'd0, 1'b0, 5'd6, 1'b1, 5'd4,  1'b0, 2'b00, 2'b00, 1'b0}  // R6 wb no write
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] dec_src1, dec_src2, exe_src1, exe_src2, exe_dst, mem_dst, wb_dst;
  logic exe_is_load, mem_wen, wb_wen;
  logic [1:0] opa_sel, opb_sel;
  logic hold, flush;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  hz_ctrl #(.REG_W(W)) dut (.*);

  // Independent reference: per operand, newest eligible producer first
  function automatic logic [1:0] ref_sel(input logic [W-1:0] s);
    logic mem_ok, wb_ok;
    mem_ok = (mem_dst == s) & mem_wen & (|mem_dst);
    wb_ok  = (wb_dst == s) & wb_wen & (|wb_dst);
    return {mem_ok, wb_ok & ~mem_ok};
  endfunction

  function automatic logic ref_hold();
    return exe_is_load & (exe_dst != 0) & ((dec_src1 == exe_dst) | (dec_src2 == exe_dst));
  endfunction

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    dec_src1 = v.d1; dec_src2 = v.d2; exe_src1 = v.x1; exe_src2 = v.x2;
    exe_dst = v.xd; exe_is_load = v.xl; mem_dst = v.md; mem_wen = v.mw;
    wb_dst = v.wd; wb_wen = v.ww;
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // Reset state: all inputs zero (R11)
    drive('0);
    chk("R11 opa", opa_sel, 2'b00);
    chk("R11 opb", opb_sel, 2'b00);
    chk("R11 hold", {1'b0, hold}, 2'b00);
    chk("R11 flush", {1'b0, flush}, 2'b00);

    // Table walk (R2..R8)
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      chk("R2/R3/R4/R5/R6 opa", opa_sel, VECS[i].ea);
      chk("R2/R3/R4/R5/R6 opb", opb_sel, VECS[i].eb);
      chk("R7/R8 hold", {1'b0, hold}, {1'b0, VECS[i].es});
      chk("R9 flush", {1'b0, flush}, {1'b0, hold});
    end

    // R10: change only operand B's source, operand A must stay put
    drive('{5'd0, 5'd0, 5'd7, 5'd7, 5'd0, 1'b0, 5'd7, 1'b1, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0});
    chk("R10 opa before", opa_sel, 2'b10);
    drive('{5'd0, 5'd0, 5'd7, 5'd2, 5'd0, 1'b0, 5'd7, 1'b1, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0});
    chk("R10 opa after", opa_sel, 2'b10);
    chk("R10 opb after", opb_sel, 2'b00);

    // Pseudo-random sweep over a small register range (R1..R9)
    for (int n = 0; n < 3000; n++) begin
      vec_t v;
      v = '0;
      v.d1 = W'($urandom_range(0, 3)); v.d2 = W'($urandom_range(0, 3));
      v.x1 = W'($urandom_range(0, 3)); v.x2 = W'($urandom_range(0, 3));
      v.xd = W'($urandom_range(0, 3)); v.xl = 1'($urandom_range(0, 1));
      v.md = W'($urandom_range(0, 3)); v.mw = 1'($urandom_range(0, 1));
      v.wd = W'($urandom_range(0, 3)); v.ww = 1'($urandom_range(0, 1));
      drive(v);
      chk("R1 opa code", {1'b0, opa_sel == 2'b11}, 2'b00);
      chk("R2/R3/R4 opa", opa_sel, ref_sel(exe_src1));
      chk("R2/R3/R4 opb", opb_sel, ref_sel(exe_src2));
      chk("R7/R8 hold", {1'b0, hold}, {1'b0, ref_hold()});
      chk("R9 flush", {1'b0, flush}, {1'b0, ref_hold()});
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule